// File: doc/BRIEF.md
# Rectangle copy blitter with raster operations

This block moves a rectangle of pixels from one surface to another in a flat, byte-addressed memory. Each destination pixel is the bitwise result of an 8-bit raster-operation code. The code is looked up per bit with three selector bits: the pattern (a fill colour), the source pixel and the existing destination pixel. A single synchronous memory port serves both surfaces. For every destination pixel the block reads the source pixel, reads the destination pixel, and then writes the combined value back. It finishes that pixel before it starts the next one.

A command is offered with a valid/ready handshake. It carries both base addresses, both signed pitches, the source start point, a destination rectangle given as an inclusive start corner and an exclusive end corner, the pixel size, the operation code, a fill flag and two lane-write enables. The command is checked when it is accepted. A malformed command ends with an error flag and touches no memory. A rectangle with no area ends at once, without an error. A negative source pitch walks the source rows towards lower addresses, which mirrors the image vertically.

Top module: `rect_blit`

## Requirements
- R1: After reset, cmd_ready is 1 and busy, done and mem_req are 0.
- R2: For each bit position k of a written pixel, the result bit is rop[{pattern[k], source[k], destination[k]}], with the pattern bit as the most significant index bit. Examples: 0xCC gives the source, 0xAA keeps the destination, 0x66 gives source XOR destination, 0x55 gives the inverted destination, 0x00 clears, 0xFF sets and 0xF0 gives the pattern.
- R3: cmd_pix_size selects the pixel width: 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. Memory data is little-endian: byte i of mem_rdata/mem_wdata (bits 8i+7..8i) belongs to address mem_addr+i, and only the bytes of the pixel are written.
- R4: A pixel at (x, y) lies at base + y·pitch + x·bytes. Source pixel (sx + x - x1, sy + y - y1) pairs with destination pixel (x, y). Pixels are handled in row-major order. Each destination pixel is read and then written at the same address in the next cycle.
- R5: If x2 ≤ x1 or y2 ≤ y1 and the command is otherwise valid, done pulses with done_err 0 and no memory access takes place.
- R6: Pitches are signed 16-bit byte counts. A negative source pitch makes successive destination rows read source rows at successively lower addresses.
- R7: A command whose source x/y or any destination coordinate is 32768 or more ends with done and done_err 1 and makes no memory access.
- R8: A command whose pitch is not a multiple of 4, whose base is not a multiple of the pixel size, or whose cmd_pix_size is 3 ends with done and done_err 1 and makes no memory access.
- R9: In 4-byte mode, cmd_wr_alpha enables byte 3 and cmd_wr_rgb enables bytes 0 to 2. In 1- and 2-byte modes both enables are ignored.
- R10: With cmd_fill set, no source read is made and the source bits are 0. The pattern is fill_color as captured at command accept; later changes to fill_color do not affect the command.
- R11: cmd_ready is 0 from accept until done. done is a single-cycle pulse. An accepted command that does work makes exactly one write per pixel and one read per pixel plus one more per pixel unless in fill mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_src_base | input | AW | Source surface byte address |
| cmd_dst_base | input | AW | Destination surface byte address |
| cmd_src_pitch | input | 16 | Signed source row stride in bytes |
| cmd_dst_pitch | input | 16 | Signed destination row stride in bytes |
| cmd_src_x | input | 16 | Source start column |
| cmd_src_y | input | 16 | Source start row |
| cmd_dst_x1 | input | 16 | Destination start column |
| cmd_dst_y1 | input | 16 | Destination start row |
| cmd_dst_x2 | input | 16 | Destination end column, exclusive |
| cmd_dst_y2 | input | 16 | Destination end row, exclusive |
| cmd_pix_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| cmd_rop | input | 8 | Raster-operation code |
| cmd_fill | input | 1 | Fill mode, no source read |
| cmd_wr_alpha | input | 1 | 4-byte mode: write byte 3 |
| cmd_wr_rgb | input | 1 | 4-byte mode: write bytes 0..2 |
| fill_color | input | 32 | Pattern value, captured at accept |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Qualifies done: command rejected |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the pixel |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The main path is run with several operation codes that separate the three index bits. Plain copy and keep-destination show whether the source and destination selectors are swapped. XOR and invert show whether both selectors take part per bit. Clear and set show the constant ends of the code. A mixed code with a striped fill colour shows whether the pattern sits at the top of the index and whether the colour was captured at accept, since the bench changes fill_color right after accept. These codes are run at all three pixel sizes, with alpha-only, colour-only and fill writes, with a negative source pitch, with a single-pixel rectangle, and with empty and malformed commands. Those last commands must leave memory untouched, and the read and write counts on the port must match the pixel count.

// File: rtl/blit_pkg.sv
package blit_pkg;

    // Coordinates and pitches are fixed at 16 bits by the command format.
    localparam int unsigned CW    = 16;
    // Widest pixel handled, in bits and in bytes.
    localparam int unsigned PIX_W = 32;
    localparam int unsigned PIX_B = PIX_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE,
        ST_FIN
    } blit_state_e;

    // Lane enables for a pixel of 2**shamt bytes.
    function automatic logic [PIX_B-1:0] lane_mask(input logic [1:0] shamt,
                                                   input logic en_alpha,
                                                   input logic en_rgb);
        case (shamt)
            2'd0:    lane_mask = 4'b0001;
            2'd1:    lane_mask = 4'b0011;
            default: lane_mask = {en_alpha, {3{en_rgb}}};
        endcase
    endfunction

endpackage

// File: rtl/blit_rop.sv
module blit_rop #(
    parameter int unsigned W = 32
) (
    input  logic [7:0]   rop,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic [W-1:0] res
);

    // One 8:1 selection per bit, indexed by pattern/source/destination.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res[i] = rop[{pat[i], src[i], dst[i]}];
    end

    always_comb begin
        if (rop == 8'hCC) begin
            // R2
            copy_rop_chk: assert (res == src);
        end
        if (rop == 8'hAA) begin
            // R2
            keep_rop_chk: assert (res == dst);
        end
    end

endmodule

// File: rtl/blit_cmd_check.sv
module blit_cmd_check #(
    parameter int unsigned CW = 16
) (
    input  logic [1:0]    src_base_lo,
    input  logic [1:0]    dst_base_lo,
    input  logic [CW-1:0] src_pitch,
    input  logic [CW-1:0] dst_pitch,
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    input  logic [CW-1:0] x2,
    input  logic [CW-1:0] y2,
    input  logic [1:0]    pix_size,
    output logic          bad,
    output logic          empty,
    output logic [1:0]    shamt
);

    logic coord_big;
    logic pitch_odd;
    logic base_odd;

    always_comb begin
        shamt     = pix_size;
        coord_big = src_x[CW-1] | src_y[CW-1] | x1[CW-1] | y1[CW-1] | x2[CW-1] | y2[CW-1];
        pitch_odd = (src_pitch[1:0] != 2'b00) || (dst_pitch[1:0] != 2'b00);
        case (pix_size)
            2'd0:    base_odd = 1'b0;
            2'd1:    base_odd = src_base_lo[0] | dst_base_lo[0];
            default: base_odd = (src_base_lo != 2'b00) || (dst_base_lo != 2'b00);
        endcase
        bad   = coord_big | pitch_odd | base_odd | (pix_size == 2'd3);
        empty = !bad && ((x2 <= x1) || (y2 <= y1));
    end

endmodule

// File: rtl/rect_blit.sv
module rect_blit
    import blit_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [AW-1:0]       cmd_src_base,
    input  logic [AW-1:0]       cmd_dst_base,
    input  logic [15:0]         cmd_src_pitch,
    input  logic [15:0]         cmd_dst_pitch,
    input  logic [15:0]         cmd_src_x,
    input  logic [15:0]         cmd_src_y,
    input  logic [15:0]         cmd_dst_x1,
    input  logic [15:0]         cmd_dst_y1,
    input  logic [15:0]         cmd_dst_x2,
    input  logic [15:0]         cmd_dst_y2,
    input  logic [1:0]          cmd_pix_size,
    input  logic [7:0]          cmd_rop,
    input  logic                cmd_fill,
    input  logic                cmd_wr_alpha,
    input  logic                cmd_wr_rgb,
    input  logic [31:0]         fill_color,
    output logic                busy,
    output logic                done,
    output logic                done_err,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [3:0]          mem_be,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata
);

    localparam int unsigned XW = AW - CW;

    typedef struct packed {
        blit_state_e       st;
        logic              err;
        logic [AW-1:0]     src_row;
        logic [AW-1:0]     dst_row;
        logic [AW-1:0]     src_ptr;
        logic [AW-1:0]     dst_ptr;
        logic [AW-1:0]     src_step;
        logic [AW-1:0]     dst_step;
        logic [CW-1:0]     x;
        logic [CW-1:0]     x1;
        logic [CW-1:0]     x2;
        logic [CW-1:0]     y;
        logic [CW-1:0]     y2;
        logic [1:0]        shamt;
        logic [PIX_B-1:0]  be;
        logic [7:0]        rop;
        logic              fill;
        logic [PIX_W-1:0]  pat;
        logic [PIX_W-1:0]  src_pix;
    } blit_regs_t;

    blit_regs_t r_d, r_q;

    // ---------------- command check ----------------
    logic       chk_bad, chk_empty;
    logic [1:0] chk_shamt;

    blit_cmd_check #(.CW(CW)) u_check (
        .src_base_lo (cmd_src_base[1:0]),
        .dst_base_lo (cmd_dst_base[1:0]),
        .src_pitch   (cmd_src_pitch),
        .dst_pitch   (cmd_dst_pitch),
        .src_x       (cmd_src_x),
        .src_y       (cmd_src_y),
        .x1          (cmd_dst_x1),
        .y1          (cmd_dst_y1),
        .x2          (cmd_dst_x2),
        .y2          (cmd_dst_y2),
        .pix_size    (cmd_pix_size),
        .bad         (chk_bad),
        .empty       (chk_empty),
        .shamt       (chk_shamt)
    );

    // ---------------- start addresses ----------------
    logic [AW-1:0] sp_ext, dp_ext;
    logic [AW-1:0] sy_ext, sx_ext, dy_ext, dx_ext;
    logic [AW-1:0] src_start, dst_start;
    logic [AW-1:0] pix_bytes;

    assign sp_ext    = {{XW{cmd_src_pitch[CW-1]}}, cmd_src_pitch};
    assign dp_ext    = {{XW{cmd_dst_pitch[CW-1]}}, cmd_dst_pitch};
    assign sy_ext    = {{XW{1'b0}}, cmd_src_y};
    assign sx_ext    = {{XW{1'b0}}, cmd_src_x};
    assign dy_ext    = {{XW{1'b0}}, cmd_dst_y1};
    assign dx_ext    = {{XW{1'b0}}, cmd_dst_x1};
    // The low AW bits of the product are correct for a signed pitch.
    assign src_start = cmd_src_base + sy_ext * sp_ext + (sx_ext << chk_shamt);
    assign dst_start = cmd_dst_base + dy_ext * dp_ext + (dx_ext << chk_shamt);
    assign pix_bytes = AW'(4'd1 << r_q.shamt);

    // ---------------- raster operation ----------------
    logic [PIX_W-1:0] rop_res;

    blit_rop #(.W(PIX_W)) u_rop (
        .rop (r_q.rop),
        .pat (r_q.pat),
        .src (r_q.src_pix),
        .dst (mem_rdata),
        .res (rop_res)
    );

    // ---------------- next state ----------------
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.err      = chk_bad;
                    r_d.src_row  = src_start;
                    r_d.dst_row  = dst_start;
                    r_d.src_ptr  = src_start;
                    r_d.dst_ptr  = dst_start;
                    r_d.src_step = sp_ext;
                    r_d.dst_step = dp_ext;
                    r_d.x        = cmd_dst_x1;
                    r_d.x1       = cmd_dst_x1;
                    r_d.x2       = cmd_dst_x2;
                    r_d.y        = cmd_dst_y1;
                    r_d.y2       = cmd_dst_y2;
                    r_d.shamt    = chk_shamt;
                    r_d.be       = lane_mask(chk_shamt, cmd_wr_alpha, cmd_wr_rgb);
                    r_d.rop      = cmd_rop;
                    r_d.fill     = cmd_fill;
                    r_d.pat      = fill_color;
                    r_d.src_pix  = '0;
                    if (chk_bad || chk_empty) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = cmd_fill ? ST_RD_DST : ST_RD_SRC;
                    end
                end
            end
            ST_RD_SRC: begin
                r_d.st = ST_RD_DST;
            end
            ST_RD_DST: begin
                // The source read issued last cycle returns now.
                if (!r_q.fill) begin
                    r_d.src_pix = mem_rdata;
                end
                r_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if ((r_q.x + 16'd1) == r_q.x2) begin
                    if ((r_q.y + 16'd1) == r_q.y2) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.x       = r_q.x1;
                        r_d.y       = r_q.y + 16'd1;
                        r_d.src_row = r_q.src_row + r_q.src_step;
                        r_d.dst_row = r_q.dst_row + r_q.dst_step;
                        r_d.src_ptr = r_q.src_row + r_q.src_step;
                        r_d.dst_ptr = r_q.dst_row + r_q.dst_step;
                        r_d.st      = r_q.fill ? ST_RD_DST : ST_RD_SRC;
                    end
                end else begin
                    r_d.x       = r_q.x + 16'd1;
                    r_d.src_ptr = r_q.src_ptr + pix_bytes;
                    r_d.dst_ptr = r_q.dst_ptr + pix_bytes;
                    r_d.st      = r_q.fill ? ST_RD_DST : ST_RD_SRC;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- outputs ----------------
    assign cmd_ready = (r_q.st == ST_IDLE);
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FIN);
    assign done_err  = done && r_q.err;
    assign mem_req   = (r_q.st == ST_RD_SRC) || (r_q.st == ST_RD_DST) || (r_q.st == ST_WRITE);
    assign mem_we    = (r_q.st == ST_WRITE);
    assign mem_addr  = (r_q.st == ST_RD_SRC) ? r_q.src_ptr : r_q.dst_ptr;
    assign mem_be    = r_q.be;
    assign mem_wdata = rop_res;

    // ---------------- assertions ----------------
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req && !mem_we) && (mem_addr == $past(mem_addr))));

    // R5 R7 R8
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (chk_bad || chk_empty)) |=> (done && !mem_req));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req);

    // R10
    fill_no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && r_q.fill) |-> (mem_addr == r_q.dst_ptr));

endmodule

// File: tb/test_rect_blit.sv
module test_rect_blit;

    typedef struct packed {
        logic [15:0] sb;
        logic [15:0] db;
        logic [15:0] sp;
        logic [15:0] dp;
        logic [15:0] sx;
        logic [15:0] sy;
        logic [15:0] x1;
        logic [15:0] y1;
        logic [15:0] x2;
        logic [15:0] y2;
        logic [1:0]  bs;
        logic [7:0]  rop;
        logic        fl;
        logic        wa;
        logic        wr;
        logic [31:0] col;
        logic        xerr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 16'h0800, 16'd16, 16'd16, 16'd1, 16'd1, 16'd2, 16'd1, 16'd6, 16'd4, 2'd0, 8'hCC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0140, 16'h0900, 16'd32, 16'd32, 16'd0, 16'd2, 16'd1, 16'd0, 16'd4, 16'd3, 2'd1, 8'h66, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0200, 16'h0A00, 16'd64, 16'd64, 16'd1, 16'd0, 16'd0, 16'd1, 16'd3, 16'd3, 2'd2, 8'h55, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0},
        '{16'h0200, 16'h0B00, 16'd64, 16'd64, 16'd0, 16'd0, 16'd1, 16'd0, 16'd4, 16'd2, 2'd2, 8'hCC, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0},
        '{16'h0000, 16'h0C00, 16'd32, 16'd32, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3, 16'd2, 2'd2, 8'hF0, 1'b1, 1'b1, 1'b0, 32'hA5123456, 1'b0},
        '{16'h0300, 16'h0D00, 16'hFFF0, 16'd16, 16'd0, 16'd3, 16'd0, 16'd0, 16'd5, 16'd4, 2'd0, 8'hCC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0140, 16'h0E00, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 2'd0, 8'hB8, 1'b0, 1'b0, 1'b0, 32'h0F0F0F0F, 1'b0},
        '{16'h0100, 16'h0E40, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3, 16'd2, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0100, 16'h0E80, 16'd32, 16'd32, 16'd0, 16'd0, 16'd1, 16'd0, 16'd3, 16'd2, 2'd2, 8'hFF, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0},
        '{16'h0100, 16'h0EC0, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 2'd0, 8'hAA, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0000, 16'h0F00, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 16'd2, 2'd2, 8'hF0, 1'b1, 1'b1, 1'b1, 32'h11223344, 1'b0},
        '{16'h0000, 16'h0F40, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 16'd2, 2'd2, 8'hCC, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0},
        '{16'h0100, 16'h0800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd3, 16'd0, 16'd3, 16'd2, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0100, 16'h0800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 16'd1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{16'h0100, 16'h0800, 16'd16, 16'd16, 16'h8000, 16'd0, 16'd0, 16'd0, 16'd2, 16'd1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1},
        '{16'h0100, 16'h0800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 16'h8000, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1},
        '{16'h0100, 16'h0800, 16'd18, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 16'd1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1},
        '{16'h0100, 16'h0901, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 16'd1, 2'd1, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1},
        '{16'h0100, 16'h0800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 16'd1, 2'd3, 8'hFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_src_base, cmd_dst_base;
    logic [15:0] cmd_src_pitch, cmd_dst_pitch;
    logic [15:0] cmd_src_x, cmd_src_y, cmd_dst_x1, cmd_dst_y1, cmd_dst_x2, cmd_dst_y2;
    logic [1:0]  cmd_pix_size;
    logic [7:0]  cmd_rop;
    logic        cmd_fill, cmd_wr_alpha, cmd_wr_rgb;
    logic [31:0] fill_color;
    logic        busy, done, done_err;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    always #5 clk = ~clk;

    rect_blit #(.AW(32)) i_rect_blit (
        .clk, .rst_n, .cmd_valid, .cmd_ready,
        .cmd_src_base, .cmd_dst_base, .cmd_src_pitch, .cmd_dst_pitch,
        .cmd_src_x, .cmd_src_y, .cmd_dst_x1, .cmd_dst_y1, .cmd_dst_x2, .cmd_dst_y2,
        .cmd_pix_size, .cmd_rop, .cmd_fill, .cmd_wr_alpha, .cmd_wr_rgb, .fill_color,
        .busy, .done, .done_err,
        .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata
    );

    // Byte memory with one-cycle read latency.
    logic [7:0] mem     [0:4095];
    logic [7:0] exp_mem [0:4095];
    int n_rd, n_wr;
    int tests, fails;
    logic [11:0] ma;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                n_wr++;
                for (int i = 0; i < 4; i++) begin
                    ma = mem_addr[11:0] + 12'(i);
                    if (mem_be[i]) mem[ma] <= mem_wdata[8*i +: 8];
                end
            end else begin
                n_rd++;
                for (int i = 0; i < 4; i++) begin
                    ma = mem_addr[11:0] + 12'(i);
                    mem_rdata[8*i +: 8] <= mem[ma];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            0:       return "R2 R4 copy";
            1:       return "R2 R3 xor 2B";
            2:       return "R2 R3 invert 4B";
            3:       return "R9 rgb-only";
            4:       return "R9 R10 alpha-only fill";
            5:       return "R6 flip";
            6:       return "R2 R10 pattern";
            7:       return "R2 R3 clear";
            8:       return "R2 set";
            9:       return "R2 keep";
            10:      return "R10 fill";
            11:      return "R10 fill zero src";
            12, 13:  return "R5 empty";
            14, 15:  return "R7 coord";
            default: return "R8 align";
        endcase
    endfunction

    // Reference: in-place, row-major, on exp_mem.
    task automatic model(input vec_t v);
        int nb, sp, dp, sa, da;
        logic [7:0] s [4];
        logic [7:0] d, p, r;
        bit en;
        if (v.xerr || v.x2 <= v.x1 || v.y2 <= v.y1) return;
        nb = 1 << v.bs;
        sp = int'($signed(v.sp));
        dp = int'($signed(v.dp));
        for (int y = int'(v.y1); y < int'(v.y2); y++) begin
            for (int x = int'(v.x1); x < int'(v.x2); x++) begin
                sa = int'(v.sb) + (int'(v.sy) + y - int'(v.y1)) * sp + (int'(v.sx) + x - int'(v.x1)) * nb;
                da = int'(v.db) + y * dp + x * nb;
                for (int b = 0; b < nb; b++) s[b] = v.fl ? 8'h00 : exp_mem[(sa + b) & 4095];
                for (int b = 0; b < nb; b++) begin
                    en = (nb < 4) ? 1'b1 : ((b == 3) ? v.wa : v.wr);
                    d  = exp_mem[(da + b) & 4095];
                    p  = v.col[8*b +: 8];
                    for (int k = 0; k < 8; k++) r[k] = v.rop[{p[k], s[b][k], d[k]}];
                    if (en) exp_mem[(da + b) & 4095] = r;
                end
            end
        end
    endtask

    task automatic run_vec(input int idx, input vec_t v, input string tag);
        int cyc, npix, mism;
        bit got_err, ready_seen;
        model(v);
        @(negedge clk);
        cmd_src_base  = {16'h0, v.sb};
        cmd_dst_base  = {16'h0, v.db};
        cmd_src_pitch = v.sp;
        cmd_dst_pitch = v.dp;
        cmd_src_x     = v.sx;
        cmd_src_y     = v.sy;
        cmd_dst_x1    = v.x1;
        cmd_dst_y1    = v.y1;
        cmd_dst_x2    = v.x2;
        cmd_dst_y2    = v.y2;
        cmd_pix_size  = v.bs;
        cmd_rop       = v.rop;
        cmd_fill      = v.fl;
        cmd_wr_alpha  = v.wa;
        cmd_wr_rgb    = v.wr;
        fill_color    = v.col;
        cmd_valid     = 1'b1;
        n_rd = 0;
        n_wr = 0;
        @(negedge clk);
        cmd_valid  = 1'b0;
        fill_color = ~v.col;   // R10: must not reach the running command
        chk(busy && !cmd_ready, "R11", "busy after accept", {busy, cmd_ready}, 2'b10);
        cyc = 0;
        ready_seen = 1'b0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (cmd_ready) ready_seen = 1'b1;
        end
        chk(done, tag, "done reached", done, 1);
        chk(!ready_seen, "R11", "ready while busy", ready_seen, 0);
        got_err = done_err;
        chk(got_err == v.xerr, tag, "error flag", got_err, v.xerr);
        @(negedge clk);
        chk(!done, "R11", "done single pulse", done, 0);
        npix = (v.xerr || v.x2 <= v.x1 || v.y2 <= v.y1) ? 0
             : int'(v.x2 - v.x1) * int'(v.y2 - v.y1);
        chk(n_wr == npix, tag, "write count", n_wr, npix);
        chk(n_rd == (v.fl ? npix : 2 * npix), tag, "read count", n_rd, v.fl ? npix : 2 * npix);
        mism = 0;
        for (int a = 0; a < 4096; a++) begin
            if (mem[a] !== exp_mem[a]) mism++;
            exp_mem[a] = mem[a];
        end
        chk(mism == 0, tag, $sformatf("memory bytes (vector %0d)", idx), mism, 0);
    endtask

    initial begin
        #2000000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        vec_t one;
        tests = 0;
        fails = 0;
        n_rd = 0;
        n_wr = 0;
        mem_rdata = '0;
        for (int a = 0; a < 4096; a++) begin
            mem[a]     = 8'(a * 7 + 3);
            exp_mem[a] = 8'(a * 7 + 3);
        end
        cmd_valid = 1'b0;
        cmd_src_base = '0; cmd_dst_base = '0;
        cmd_src_pitch = '0; cmd_dst_pitch = '0;
        cmd_src_x = '0; cmd_src_y = '0;
        cmd_dst_x1 = '0; cmd_dst_y1 = '0; cmd_dst_x2 = '0; cmd_dst_y2 = '0;
        cmd_pix_size = '0; cmd_rop = '0; cmd_fill = 1'b0;
        cmd_wr_alpha = 1'b0; cmd_wr_rgb = 1'b0; fill_color = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_ready && !busy && !done && !mem_req, "R1", "state in reset",
            {cmd_ready, busy, done, mem_req}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_ready && !busy && !done && !mem_req, "R1", "state after reset",
            {cmd_ready, busy, done, mem_req}, 4'b1000);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i], vtag(i));

        // R4 corner: single-pixel rectangle at a far column, 4-byte pixels.
        one = '{16'h0010, 16'h0F80, 16'd64, 16'd64, 16'd7, 16'd2, 16'd5, 16'd0,
                16'd6, 16'd1, 2'd2, 8'h66, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0};
        run_vec(100, one, "R4 single pixel");
        // R6 corner: negative source pitch with 2-byte pixels.
        one = '{16'h0380, 16'h0FC0, 16'hFFE0, 16'd16, 16'd1, 16'd2, 16'd0, 16'd0,
                16'd3, 16'd3, 2'd1, 8'hCC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0};
        run_vec(101, one, "R6 flip 2B");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule